// File: doc/BRIEF.md
# Two-Thread Reorder Buffer Allocator

This block hands out reorder-buffer slots to two hardware threads and retires them in program order for each thread. A dispatch request names a thread and, in the same cycle, is either given a slot index or told to stall. A completion names a slot and may flag an exception. Each thread has its own oldest-entry pointer, allocation pointer, occupancy count and commit program counter. One thread can retire and another can flush in the same cycle, and neither disturbs the other.

Two settings select the slot budget. In shared mode either thread may take any number of slots up to the full capacity. In partitioned mode a lone active thread gets the whole buffer, but with two threads active each is held to its own half, however empty the other half is. When only one thread is active, thread 0 is the active one and thread 1 always stalls. A new setting takes effect only when the buffer is empty.

Every slot records its thread and a per-thread sequence number. The oldest entry of a thread is found by matching that number against the thread's head counter, so one storage layout serves both modes. When the oldest entry of a thread holds an exception, all entries of that thread are dropped. That thread's counters are then cleared and the thread and its commit PC are reported.

Top module: `robmt_alloc`

## Requirements
- R1: In shared mode (mode_part=0) with two threads active (mode_dual=1), both threads draw from all 16 slots in any split. A request stalls once the two threads together hold 16.
- R2: With one thread active (mode_dual=0), thread 0 (disp_tid=0) may take all 16 slots in either mode, and every request from thread 1 stalls.
- R3: In partitioned mode with two threads active, thread 0 receives only slots 0–7 and thread 1 only slots 8–15. Each thread stalls at 8 entries, even when the other thread holds fewer.
- R4: disp_stall is combinational and is raised in the request's own cycle. A request that does not stall gets the lowest-numbered free slot in the thread's allowed window, and that slot is allocated at the next clock edge.
- R5: Each thread retires at most one entry per cycle, and always its oldest entry. ret_valid[t] rises only once that oldest entry is complete, so completing a younger entry first produces no retirement.
- R6: After reset, each thread's commit PC equals RESET_PC (0x0100). It advances by 4 on each retirement of that thread.
- R7: An oldest entry completed with cmp_exc=1 raises flush_valid, with flush_tid set to its thread and flush_pc set to that thread's commit PC. At the next edge that thread's occupancy becomes 0, and the other thread's entries, occupancy and PC stay unchanged. If both threads except together, thread 0 is reported first.
- R8: cfg_part and cfg_dual are copied into mode_part and mode_dual only at an edge where both occupancies are 0 and no slot is being allocated. Otherwise the mode stays unchanged.
- R9: During reset, both occupancies are 0, ret_valid and flush_valid are 0, mode is shared with one active thread, and both commit PCs equal RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_part | input | 1 | Requested mode: 1 partitioned, 0 shared |
| cfg_dual | input | 1 | Requested thread count: 1 two threads, 0 thread 0 only |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | 1 | Thread of the dispatch request |
| disp_stall | output | 1 | Request cannot be accepted this cycle |
| disp_idx | output | 4 | Slot given to an accepted request |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | 4 | Slot being completed |
| cmp_exc | input | 1 | Completion carries an exception |
| ret_valid | output | 2 | Per-thread retire strobe, bit t for thread t |
| ret_idx | output | 8 | Per-thread retiring slot, bits [4t+3:4t] |
| flush_valid | output | 1 | Thread flush this cycle |
| flush_tid | output | 1 | Thread being flushed |
| flush_pc | output | 16 | Commit PC of the flushed thread |
| occ | output | 10 | Per-thread occupancy, bits [5t+4:5t] |
| commit_pc | output | 32 | Per-thread commit PC, bits [16t+15:16t] |
| mode_part | output | 1 | Mode in effect: partitioned |
| mode_dual | output | 1 | Mode in effect: two threads |

## Verification
Allocation is driven into each of the three budgets: shared with two threads, partitioned with one thread and partitioned with two threads. Each thread is filled while the other is nearly empty, which tells a per-thread cap apart from a total-capacity limit and shows whether slot indices stay inside each thread's half. Completions arrive out of order, an exception hits one thread while the other holds entries, and a mode change is attempted on a non-empty buffer. A seeded random phase then mixes dispatch and completion on both threads and compares stall, slot index, occupancy and the order of retirements with a per-thread queue model.

// File: rtl/robmt_pkg.sv
package robmt_pkg;
  localparam int NTHR = 2;
  typedef logic [0:0] tid_t;
  typedef struct packed {
    logic part;
    logic dual;
  } mode_t;
endpackage

// File: rtl/robmt_pick.sv
module robmt_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  input  logic [IDX_W-1:0] win_lo,
  input  logic [IDX_W-1:0] win_hi,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest free slot inside [win_lo, win_hi]
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (!busy[e] && e >= int'(win_lo) && e <= int'(win_hi)) begin
        found = 1'b1;
        idx   = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/robmt_oldest.sv
module robmt_oldest #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = IDX_W + 1
) (
  input  logic [DEPTH-1:0]       mine,
  input  logic [DEPTH*SEQ_W-1:0] seq_flat,
  input  logic [SEQ_W-1:0]       head,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (mine[e] && seq_flat[e*SEQ_W +: SEQ_W] == head) begin
        found = 1'b1;
        idx   = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/robmt_alloc.sv
module robmt_alloc
  import robmt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W = 16,
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter int PC_STEP = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_part,
  input  logic                    cfg_dual,
  input  logic                    disp_valid,
  input  logic                    disp_tid,
  output logic                    disp_stall,
  output logic [IDX_W-1:0]        disp_idx,
  input  logic                    cmp_valid,
  input  logic [IDX_W-1:0]        cmp_idx,
  input  logic                    cmp_exc,
  output logic [NTHR-1:0]         ret_valid,
  output logic [NTHR*IDX_W-1:0]   ret_idx,
  output logic                    flush_valid,
  output logic                    flush_tid,
  output logic [PC_W-1:0]         flush_pc,
  output logic [NTHR*SEQ_W-1:0]   occ,
  output logic [NTHR*PC_W-1:0]    commit_pc,
  output logic                    mode_part,
  output logic                    mode_dual
);
  localparam int HALF = DEPTH / 2;

  // slot state
  logic [DEPTH-1:0] ent_vld_q, ent_tid_q, ent_done_q, ent_exc_q;
  logic [DEPTH-1:0] n_vld, n_tid, n_done, n_exc, ent_we;
  logic [SEQ_W-1:0] ent_seq_q [DEPTH];
  logic [SEQ_W-1:0] n_seq     [DEPTH];
  logic [DEPTH*SEQ_W-1:0] seq_flat;

  // per-thread state
  logic [SEQ_W-1:0] head_q [NTHR], tail_q [NTHR], n_head [NTHR], n_tail [NTHR];
  logic [SEQ_W-1:0] occ_w  [NTHR], lim [NTHR];
  logic [PC_W-1:0]  pc_q   [NTHR], n_pc [NTHR];
  logic [DEPTH-1:0] mine   [NTHR];
  logic [NTHR-1:0]  old_found, exc_cand, ret_go, flush_go, thr_block;
  logic [IDX_W-1:0] old_idx [NTHR];

  mode_t mode_q;
  logic  mode_we, buf_empty, disp_fire, pick_found;
  logic [IDX_W-1:0] win_lo, win_hi, pick_idx;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_flat
      assign seq_flat[e*SEQ_W +: SEQ_W] = ent_seq_q[e];
    end
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      for (genvar e = 0; e < DEPTH; e++) begin : g_mine
        assign mine[t][e] = ent_vld_q[e] && (ent_tid_q[e] == tid_t'(t));
      end
      robmt_oldest #(.DEPTH(DEPTH)) u_oldest (
        .mine    (mine[t]),
        .seq_flat(seq_flat),
        .head    (head_q[t]),
        .found   (old_found[t]),
        .idx     (old_idx[t])
      );
      assign occ_w[t]    = tail_q[t] - head_q[t];
      assign exc_cand[t] = old_found[t] && ent_done_q[old_idx[t]] && ent_exc_q[old_idx[t]];
      assign ret_go[t]   = old_found[t] && ent_done_q[old_idx[t]] && !ent_exc_q[old_idx[t]];
      assign ret_valid[t] = ret_go[t];
      assign ret_idx[t*IDX_W +: IDX_W] = old_idx[t];
      assign occ[t*SEQ_W +: SEQ_W]     = occ_w[t];
      assign commit_pc[t*PC_W +: PC_W] = pc_q[t];
      assign lim[t] = !mode_q.dual ? ((t == 0) ? SEQ_W'(DEPTH) : '0)
                    : (mode_q.part ? SEQ_W'(HALF) : SEQ_W'(DEPTH));
      assign thr_block[t] = (occ_w[t] >= lim[t]) || exc_cand[t];
    end
  endgenerate

  // thread 0 wins a simultaneous exception
  assign flush_go[0] = exc_cand[0];
  assign flush_go[1] = exc_cand[1] && !exc_cand[0];
  assign flush_valid = |flush_go;
  assign flush_tid   = !flush_go[0];
  assign flush_pc    = pc_q[flush_tid];

  // allocation window
  always_comb begin
    if (mode_q.part && mode_q.dual) begin
      win_lo = disp_tid ? IDX_W'(HALF) : '0;
      win_hi = disp_tid ? IDX_W'(DEPTH - 1) : IDX_W'(HALF - 1);
    end else begin
      win_lo = '0;
      win_hi = IDX_W'(DEPTH - 1);
    end
  end

  robmt_pick #(.DEPTH(DEPTH)) u_pick (
    .busy  (ent_vld_q),
    .win_lo(win_lo),
    .win_hi(win_hi),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign disp_stall = disp_valid && (thr_block[disp_tid] || !pick_found);
  assign disp_fire  = disp_valid && !disp_stall;
  assign disp_idx   = pick_idx;
  assign buf_empty  = (occ_w[0] == '0) && (occ_w[1] == '0);
  assign mode_we    = buf_empty && !disp_fire;
  assign mode_part  = mode_q.part;
  assign mode_dual  = mode_q.dual;

  // next state
  always_comb begin
    n_vld = ent_vld_q; n_tid = ent_tid_q; n_done = ent_done_q; n_exc = ent_exc_q;
    n_seq = ent_seq_q; ent_we = '0;
    n_head = head_q; n_tail = tail_q; n_pc = pc_q;
    if (cmp_valid && ent_vld_q[cmp_idx] && !ent_done_q[cmp_idx]) begin
      n_done[cmp_idx] = 1'b1;
      n_exc[cmp_idx]  = cmp_exc;
      ent_we[cmp_idx] = 1'b1;
    end
    if (disp_fire) begin
      n_vld[pick_idx]  = 1'b1;
      n_tid[pick_idx]  = disp_tid;
      n_done[pick_idx] = 1'b0;
      n_exc[pick_idx]  = 1'b0;
      n_seq[pick_idx]  = tail_q[disp_tid];
      ent_we[pick_idx] = 1'b1;
      n_tail[disp_tid] = tail_q[disp_tid] + 1'b1;
    end
    for (int t = 0; t < NTHR; t++) begin
      if (ret_go[t]) begin
        n_vld[old_idx[t]]  = 1'b0;
        ent_we[old_idx[t]] = 1'b1;
        n_head[t] = head_q[t] + 1'b1;
        n_pc[t]   = pc_q[t] + PC_W'(PC_STEP);
      end else if (flush_go[t]) begin
        for (int e = 0; e < DEPTH; e++) begin
          if (mine[t][e]) begin
            n_vld[e]  = 1'b0;
            ent_we[e] = 1'b1;
          end
        end
        n_head[t] = '0;
        n_tail[t] = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld_q <= '0; ent_tid_q <= '0; ent_done_q <= '0; ent_exc_q <= '0;
      for (int e = 0; e < DEPTH; e++) ent_seq_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_we[e]) begin
          ent_vld_q[e]  <= n_vld[e];
          ent_tid_q[e]  <= n_tid[e];
          ent_done_q[e] <= n_done[e];
          ent_exc_q[e]  <= n_exc[e];
          ent_seq_q[e]  <= n_seq[e];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        head_q[t] <= '0;
        tail_q[t] <= '0;
        pc_q[t]   <= RESET_PC[PC_W-1:0];
      end
      mode_q <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        head_q[t] <= n_head[t];
        tail_q[t] <= n_tail[t];
        pc_q[t]   <= n_pc[t];
      end
      if (mode_we) mode_q <= '{part: cfg_part, dual: cfg_dual};
    end
  end

  // assertions
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, occ_w[0]} + {1'b0, occ_w[1]}) <= (SEQ_W+1)'(DEPTH)); // R1
  AST_IDLE_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.dual |-> occ_w[1] == '0); // R2
  AST_PART_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.part && mode_q.dual) |-> (occ_w[0] <= SEQ_W'(HALF) && occ_w[1] <= SEQ_W'(HALF))); // R3
  AST_HALF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && mode_q.part && mode_q.dual) |-> disp_idx[IDX_W-1] == disp_tid); // R3
  AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> !ent_vld_q[disp_idx]); // R4
  AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> ent_vld_q[$past(disp_idx)] && ent_tid_q[$past(disp_idx)] == $past(disp_tid)); // R4
  AST_PC_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go[0] |=> pc_q[0] == $past(pc_q[0]) + PC_W'(PC_STEP)); // R6
  AST_FLUSH_EMPTIES0: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go[0] |=> occ_w[0] == '0); // R7
  AST_FLUSH_EMPTIES1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go[1] |=> occ_w[1] == '0); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |=> $stable(mode_q)); // R8
endmodule

// File: tb/robmt_alloc_test.sv
module robmt_alloc_test;
  localparam int CLK_P = 10;
  localparam int RPC = 16'h0100;

  logic clk, rst_n, cfg_part, cfg_dual;
  logic disp_valid, disp_tid, disp_stall;
  logic [3:0] disp_idx, cmp_idx;
  logic cmp_valid, cmp_exc;
  logic [1:0] ret_valid;
  logic [7:0] ret_idx;
  logic flush_valid, flush_tid;
  logic [15:0] flush_pc;
  logic [9:0] occ;
  logic [31:0] commit_pc;
  logic mode_part, mode_dual;

  int nchk = 0, nfail = 0;

  robmt_alloc uut (
    .clk(clk), .rst_n(rst_n), .cfg_part(cfg_part), .cfg_dual(cfg_dual),
    .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_stall(disp_stall), .disp_idx(disp_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_exc(cmp_exc),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .flush_valid(flush_valid), .flush_tid(flush_tid),
    .flush_pc(flush_pc), .occ(occ), .commit_pc(commit_pc), .mode_part(mode_part), .mode_dual(mode_dual)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, settle, return before the rising edge
  task automatic cyc(input logic dv, input logic dt, input logic cv, input int ci, input logic ce);
    @(negedge clk);
    disp_valid = dv; disp_tid = dt;
    cmp_valid = cv; cmp_idx = 4'(ci); cmp_exc = ce;
    #1;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

  function automatic int occ_of(input int t); return int'(occ[t*5 +: 5]); endfunction
  function automatic int pc_of(input int t); return int'(commit_pc[t*16 +: 16]); endfunction
  function automatic int ridx(input int t); return int'(ret_idx[t*4 +: 4]); endfunction

  // random-phase model
  bit m_busy [16];
  bit m_done [16];
  int q0[$], q1[$];

  function automatic int m_pick();
    for (int e = 0; e < 16; e++) if (!m_busy[e]) return e;
    return -1;
  endfunction

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; cfg_part = 1; cfg_dual = 1;
    disp_valid = 0; disp_tid = 0; cmp_valid = 0; cmp_idx = 0; cmp_exc = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 occ0", occ_of(0), 0); chk("R9 occ1", occ_of(1), 0);
    chk("R9 ret", int'(ret_valid), 0); chk("R9 flush", int'(flush_valid), 0);
    chk("R9 mode", int'({mode_part, mode_dual}), 0);
    chk("R9 pc0", pc_of(0), RPC); chk("R9 pc1", pc_of(1), RPC);
    rst_n = 1;
    idle();
    chk("R8 mode taken when empty", int'({mode_part, mode_dual}), 3);

    // R3: partitioned, two threads
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, 0, 0, 0);
      chk("R3 t1 stall", int'(disp_stall), 0); chk("R3 t1 idx", int'(disp_idx), 8 + i);
    end
    cyc(1, 1, 0, 0, 0); chk("R3 t1 cap at half", int'(disp_stall), 1);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R4 t0 stall", int'(disp_stall), 0); chk("R4 t0 lowest idx", int'(disp_idx), i);
    end
    cyc(1, 0, 0, 0, 0); chk("R3 t0 cap at half", int'(disp_stall), 1);
    idle(); chk("R3 occ0", occ_of(0), 8); chk("R3 occ1", occ_of(1), 8);

    // R8: change refused while non-empty
    cfg_part = 0;
    idle(); idle();
    chk("R8 mode held", int'(mode_part), 1);
    cfg_part = 1;

    // R5: out-of-order completion
    cyc(0, 0, 1, 9, 0);
    idle(); chk("R5 younger done no retire", int'(ret_valid[1]), 0);
    cyc(0, 0, 1, 8, 0);
    idle(); chk("R5 retire oldest", int'(ret_valid[1]), 1); chk("R5 idx 8", ridx(1), 8);
    idle(); chk("R5 retire next", int'(ret_valid[1]), 1); chk("R5 idx 9", ridx(1), 9);
    idle(); chk("R5 stop at incomplete", int'(ret_valid[1]), 0);
    chk("R6 pc1 advanced", pc_of(1), RPC + 8); chk("R6 pc0 unchanged", pc_of(0), RPC);
    chk("R5 occ1", occ_of(1), 6);

    // R7: exception in thread 1
    cyc(0, 0, 1, 10, 1);
    idle();
    chk("R7 flush", int'(flush_valid), 1); chk("R7 tid", int'(flush_tid), 1);
    chk("R7 pc", int'(flush_pc), RPC + 8);
    idle();
    chk("R7 occ1 cleared", occ_of(1), 0); chk("R7 occ0 kept", occ_of(0), 8);
    chk("R7 pc0 kept", pc_of(0), RPC); chk("R7 flush done", int'(flush_valid), 0);

    // drain thread 0
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, i, 0);
    idle(); idle(); idle();
    chk("R6 occ0 drained", occ_of(0), 0); chk("R6 pc0", pc_of(0), RPC + 32);

    // R2: partitioned, one thread
    cfg_dual = 0;
    idle(); idle();
    chk("R2 mode", int'({mode_part, mode_dual}), 2);
    cyc(1, 1, 0, 0, 0); chk("R2 inactive stalls", int'(disp_stall), 1);
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R2 t0 stall", int'(disp_stall), 0); chk("R2 t0 idx", int'(disp_idx), i);
    end
    cyc(1, 0, 0, 0, 0); chk("R2 full stall", int'(disp_stall), 1);
    cyc(0, 0, 1, 0, 1);
    idle(); chk("R7 t0 flush", int'(flush_valid), 1); chk("R7 t0 tid", int'(flush_tid), 0);
    chk("R7 t0 pc", int'(flush_pc), RPC + 32);
    idle(); chk("R7 t0 cleared", occ_of(0), 0);

    // R1: shared, two threads
    cfg_part = 0; cfg_dual = 1;
    idle(); idle();
    chk("R1 mode", int'({mode_part, mode_dual}), 1);
    for (int i = 0; i < 12; i++) begin
      cyc(1, 1, 0, 0, 0); chk("R1 t1 idx", int'(disp_idx), i);
    end
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0, 0, 0); chk("R1 t0 idx", int'(disp_idx), 12 + i);
    end
    cyc(1, 0, 0, 0, 0); chk("R1 t0 full", int'(disp_stall), 1);
    cyc(1, 1, 0, 0, 0); chk("R1 t1 full", int'(disp_stall), 1);
    idle(); chk("R1 occ1", occ_of(1), 12); chk("R1 occ0", occ_of(0), 4);
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 1, 12, 1);
    chk("R7 t1 flush first", int'(flush_tid), 1);
    idle(); chk("R7 t0 flush next", int'(flush_tid), 0); chk("R7 t0 flag", int'(flush_valid), 1);
    idle(); chk("R7 both empty", occ_of(0) + occ_of(1), 0);

    // random phase, shared two threads
    for (int n = 0; n < 400; n++) begin
      bit er0, er1, dv, dt, cv, es;
      int ci, pk, sz;
      @(negedge clk);
      er0 = q0.size() > 0 && m_done[q0[0]];
      er1 = q1.size() > 0 && m_done[q1[0]];
      chk("R5 rand ret0", int'(ret_valid[0]), int'(er0));
      chk("R5 rand ret1", int'(ret_valid[1]), int'(er1));
      if (er0) chk("R5 rand idx0", ridx(0), q0[0]);
      if (er1) chk("R5 rand idx1", ridx(1), q1[0]);
      chk("R1 rand occ0", occ_of(0), q0.size());
      chk("R1 rand occ1", occ_of(1), q1.size());
      dv = ($urandom % 4) != 0;
      dt = 1'($urandom % 2);
      cv = 0; ci = 0;
      begin
        int st;
        st = $urandom % 16;
        for (int k = 0; k < 16; k++) begin
          int e;
          e = (st + k) % 16;
          if (!cv && m_busy[e] && !m_done[e] && ($urandom % 3) != 0) begin
            cv = 1; ci = e;
          end
        end
      end
      disp_valid = dv; disp_tid = dt; cmp_valid = cv; cmp_idx = 4'(ci); cmp_exc = 0;
      #1;
      pk = m_pick();
      sz = dt ? q1.size() : q0.size();
      es = (sz >= 16) || (pk < 0);
      if (dv) begin
        chk("R4 rand stall", int'(disp_stall), int'(es));
        if (!es) chk("R4 rand idx", int'(disp_idx), pk);
      end
      if (cv) m_done[ci] = 1;
      if (dv && !es) begin
        m_busy[pk] = 1; m_done[pk] = 0;
        if (dt) q1.push_back(pk); else q0.push_back(pk);
      end
      if (er0) begin m_busy[q0[0]] = 0; m_done[q0[0]] = 0; void'(q0.pop_front()); end
      if (er1) begin m_busy[q1[0]] = 0; m_done[q1[0]] = 0; void'(q1.pop_front()); end
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule